// File: doc/BRIEF.md
# Mask Prefix-Sum Index Generator

This block walks a vector register group one element per clock and produces, for each element, a value to be written into the destination. It has two operations. The prefix-count operation gives every active element the number of set source-mask bits found on active elements below it. The position operation gives every active element its own element number and pays no attention to the source mask. Elements whose activity bit is clear are still presented on the output stream, with their write strobe low, so the destination keeps its previous contents there.

A caller pulses `start_i` with the operation code, element width, group multiplier, start offset, register numbers and both masks. The block latches these inputs, checks the request and then either raises `illegal_o` for one cycle or streams `num_elem = VLEN * LMUL / SEW` elements in ascending order. After the last element it pulses `done_o` once. Each value is cut to the selected element width and zero-extended to the output bus.

Top module: `mask_iota_gen`

## Requirements
- R1: In the prefix-count operation (op code 5'b10000), element i carries the count, before element i's own contribution, of indices j < i with both the activity bit and the source bit set.
- R2: An element whose activity bit is 0 is emitted with `el_wr_o` = 0 and does not advance the running count. An element whose activity bit is 1 is emitted with `el_wr_o` = 1.
- R3: In the position operation (op code 5'b10001), element i carries the value i whatever the source mask holds.
- R4: Every emitted value is truncated to the element width and zero-extended to ELEN bits. The width code is 0, 1, 2 or 3 for 8, 16, 32 or 64 bits, so counts wrap modulo 2^width.
- R5: Any op code other than 5'b10000 and 5'b10001 is rejected as illegal.
- R6: The prefix-count operation is illegal when `vstart_i` is nonzero or when `vd_i` equals `vs2_i`. The position operation checks neither condition. An illegal request pulses `illegal_o` for one cycle, emits no element and gives no `done_o`.
- R7: The number of emitted elements is VLEN * LMUL / SEW, with multiplier code 0, 1, 2 or 3 meaning LMUL 1, 2, 4 or 8.
- R8: A request sampled at clock edge E emits element i, with `el_valid_o` high and `el_idx_o` = i, after edge E+1+i. `done_o` is high for exactly one cycle, after edge E+num_elem+1, while `el_valid_o` is low.
- R9: A `start_i` pulse while `busy_o` is high is ignored, and the running operation continues unchanged.
- R10: During reset, `busy_o`, `illegal_o`, `done_o`, `el_valid_o`, `el_wr_o` and `el_data_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request pulse, accepted when idle |
| op_i | input | 5 | Operation code: 10000 prefix count, 10001 position |
| sew_i | input | 2 | Element width code (8, 16, 32, 64 bits) |
| lmul_i | input | 2 | Group multiplier code (1, 2, 4, 8) |
| vstart_i | input | $clog2(VLEN) | Start offset, must be zero for prefix count |
| vd_i | input | 5 | Destination register number |
| vs2_i | input | 5 | Source mask register number |
| src_mask_i | input | VLEN | Source mask bits, bit i for element i |
| act_mask_i | input | VLEN | Activity bits, bit i for element i |
| busy_o | output | 1 | A walk is in progress |
| illegal_o | output | 1 | One-cycle pulse: request rejected |
| done_o | output | 1 | One-cycle pulse after the last element |
| el_valid_o | output | 1 | Element output valid |
| el_idx_o | output | $clog2(VLEN) | Element number |
| el_wr_o | output | 1 | Write strobe: 1 active, 0 keep old value |
| el_data_o | output | ELEN | Truncated, zero-extended element value |

## Verification
After a request is sampled at an edge, the reject pulse is visible after that same edge, element i after the (i+1)-th following edge, and the done pulse one edge after the last element. The bench drives inputs and samples outputs on falling edges. It clears `start_i` on the falling edge after the request and then reads exactly one element per falling edge, so every comparison lands in the cycle its result is due. The expected count, position and truncated value are computed in the bench from the latched masks. A stray request is injected during a walk, and runs with a full group at 8-bit width make the count wrap past 255.

// File: rtl/mask_iota_pkg.sv
`timescale 1ns/1ps
package mask_iota_pkg;

   typedef enum logic [4:0] {
      OP_PREFIX = 5'b10000,
      OP_POSIT  = 5'b10001
   } iota_op_e;

   localparam int SEW_CODES = 4;

   function automatic int lane_bits(input int code);
      return 8 << code;
   endfunction

endpackage

// File: rtl/iota_elem_count.sv
`timescale 1ns/1ps
module iota_elem_count #(
   parameter int VLEN = 128,
   parameter int IDXW = $clog2(VLEN)
) (
   input  logic [1:0]      sew_i,
   input  logic [1:0]      lmul_i,
   output logic [IDXW-1:0] last_o
);
   localparam int CW = IDXW + 1;

   logic [CW-1:0] base;
   logic [CW-1:0] count;

   always_comb begin
      base   = CW'(VLEN / 8);
      count  = (base << lmul_i) >> sew_i;
      last_o = IDXW'(count - CW'(1));
   end
endmodule

// File: rtl/iota_legal_chk.sv
`timescale 1ns/1ps
module iota_legal_chk
   import mask_iota_pkg::*;
#(
   parameter int IDXW = 7
) (
   input  logic [4:0]      op_i,
   input  logic [IDXW-1:0] vstart_i,
   input  logic [4:0]      vd_i,
   input  logic [4:0]      vs2_i,
   output logic            illegal_o,
   output logic            prefix_o
);
   logic known_op;
   logic prefix_bad;

   always_comb begin
      prefix_o   = (op_i == OP_PREFIX);
      known_op   = prefix_o || (op_i == OP_POSIT);
      prefix_bad = prefix_o && ((vstart_i != '0) || (vd_i == vs2_i));
      illegal_o  = !known_op || prefix_bad;
   end
endmodule

// File: rtl/iota_val_fmt.sv
`timescale 1ns/1ps
module iota_val_fmt
   import mask_iota_pkg::*;
#(
   parameter int ELEN = 64,
   parameter int IDXW = 7
) (
   input  logic [1:0]      sew_i,
   input  logic [IDXW-1:0] raw_i,
   output logic [ELEN-1:0] data_o
);
   logic [ELEN-1:0] lane [SEW_CODES];
   logic [ELEN-1:0] wide;

   assign wide = ELEN'(raw_i);

   for (genvar g = 0; g < SEW_CODES; g++) begin : g_lane
      localparam int W = 8 << g;
      localparam logic [ELEN-1:0] KEEP =
         (W >= ELEN) ? {ELEN{1'b1}} : ((ELEN'(1) << W) - ELEN'(1));
      assign lane[g] = wide & KEEP;
   end

   always_comb data_o = lane[sew_i];
endmodule

// File: rtl/iota_seq.sv
`timescale 1ns/1ps
module iota_seq #(
   parameter int VLEN = 128,
   parameter int IDXW = $clog2(VLEN)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start_i,
   input  logic            illegal_i,
   input  logic            prefix_i,
   input  logic [1:0]      sew_i,
   input  logic [IDXW-1:0] last_i,
   input  logic [VLEN-1:0] src_i,
   input  logic [VLEN-1:0] act_i,
   output logic            busy_o,
   output logic            illegal_o,
   output logic            done_o,
   output logic            el_valid_o,
   output logic [IDXW-1:0] el_idx_o,
   output logic            el_wr_o,
   output logic [IDXW-1:0] raw_o,
   output logic [1:0]      sew_o
);
   logic            busy_q, ill_q, done_q, v_q, wr_q, lastel_q, prefix_q;
   logic [IDXW-1:0] idx_q, sum_q, last_q, oidx_q, raw_q;
   logic [1:0]      sew_q;
   logic [VLEN-1:0] src_q, act_q;
   logic            cur_act, at_end;

   assign cur_act = act_q[idx_q];
   assign at_end  = (idx_q == last_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         ill_q    <= 1'b0;
         done_q   <= 1'b0;
         v_q      <= 1'b0;
         wr_q     <= 1'b0;
         lastel_q <= 1'b0;
         prefix_q <= 1'b0;
         idx_q    <= '0;
         sum_q    <= '0;
         last_q   <= '0;
         oidx_q   <= '0;
         raw_q    <= '0;
         sew_q    <= '0;
         src_q    <= '0;
         act_q    <= '0;
      end else begin
         ill_q  <= 1'b0;
         v_q    <= 1'b0;
         done_q <= v_q && lastel_q;
         if (!busy_q && start_i) begin
            if (illegal_i) begin
               ill_q <= 1'b1;
            end else begin
               busy_q   <= 1'b1;
               idx_q    <= '0;
               sum_q    <= '0;
               last_q   <= last_i;
               prefix_q <= prefix_i;
               sew_q    <= sew_i;
               src_q    <= src_i;
               act_q    <= act_i;
            end
         end else if (busy_q) begin
            v_q      <= 1'b1;
            oidx_q   <= idx_q;
            wr_q     <= cur_act;
            raw_q    <= prefix_q ? sum_q : idx_q;
            lastel_q <= at_end;
            if (prefix_q && cur_act && src_q[idx_q])
               sum_q <= sum_q + IDXW'(1);
            if (at_end) busy_q <= 1'b0;
            else        idx_q  <= idx_q + IDXW'(1);
         end
      end
   end

   assign busy_o     = busy_q;
   assign illegal_o  = ill_q;
   assign done_o     = done_q;
   assign el_valid_o = v_q;
   assign el_idx_o   = oidx_q;
   assign el_wr_o    = wr_q;
   assign raw_o      = raw_q;
   assign sew_o      = sew_q;
endmodule

// File: rtl/mask_iota_gen.sv
`timescale 1ns/1ps
module mask_iota_gen #(
   parameter int VLEN = 128,
   parameter int ELEN = 64,
   localparam int IDXW = $clog2(VLEN)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start_i,
   input  logic [4:0]      op_i,
   input  logic [1:0]      sew_i,
   input  logic [1:0]      lmul_i,
   input  logic [IDXW-1:0] vstart_i,
   input  logic [4:0]      vd_i,
   input  logic [4:0]      vs2_i,
   input  logic [VLEN-1:0] src_mask_i,
   input  logic [VLEN-1:0] act_mask_i,
   output logic            busy_o,
   output logic            illegal_o,
   output logic            done_o,
   output logic            el_valid_o,
   output logic [IDXW-1:0] el_idx_o,
   output logic            el_wr_o,
   output logic [ELEN-1:0] el_data_o
);
   initial begin
      assert (VLEN >= 64 && (VLEN & (VLEN - 1)) == 0)
         else $error("VLEN must be a power of two of at least 64");
      assert (ELEN >= 64)
         else $error("ELEN must hold a 64-bit element");
   end

   logic [IDXW-1:0] last_idx, raw_val;
   logic            req_bad, req_prefix;
   logic [1:0]      sew_run;

   iota_elem_count #(.VLEN(VLEN), .IDXW(IDXW)) u_cnt (
      .sew_i  (sew_i),
      .lmul_i (lmul_i),
      .last_o (last_idx)
   );

   iota_legal_chk #(.IDXW(IDXW)) u_legal (
      .op_i      (op_i),
      .vstart_i  (vstart_i),
      .vd_i      (vd_i),
      .vs2_i     (vs2_i),
      .illegal_o (req_bad),
      .prefix_o  (req_prefix)
   );

   iota_seq #(.VLEN(VLEN), .IDXW(IDXW)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .illegal_i  (req_bad),
      .prefix_i   (req_prefix),
      .sew_i      (sew_i),
      .last_i     (last_idx),
      .src_i      (src_mask_i),
      .act_i      (act_mask_i),
      .busy_o     (busy_o),
      .illegal_o  (illegal_o),
      .done_o     (done_o),
      .el_valid_o (el_valid_o),
      .el_idx_o   (el_idx_o),
      .el_wr_o    (el_wr_o),
      .raw_o      (raw_val),
      .sew_o      (sew_run)
   );

   iota_val_fmt #(.ELEN(ELEN), .IDXW(IDXW)) u_fmt (
      .sew_i  (sew_run),
      .raw_i  (raw_val),
      .data_o (el_data_o)
   );
endmodule

// File: rtl/mask_iota_gen_chk.sv
`timescale 1ns/1ps
module mask_iota_gen_chk #(
   parameter int VLEN = 128,
   parameter int ELEN = 64,
   parameter int IDXW = $clog2(VLEN)
) (
   input logic            clk,
   input logic            rst_n,
   input logic            start_i,
   input logic [4:0]      op_i,
   input logic [1:0]      sew_i,
   input logic            busy_o,
   input logic            illegal_o,
   input logic            done_o,
   input logic            el_valid_o,
   input logic [IDXW-1:0] el_idx_o,
   input logic [ELEN-1:0] el_data_o
);
   logic [4:0] op_q;
   logic [1:0] sew_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         op_q  <= '0;
         sew_q <= '0;
      end else if (start_i && !busy_o) begin
         op_q  <= op_i;
         sew_q <= sew_i;
      end
   end

   a_r1_iota_step: assert property (@(posedge clk) disable iff (!rst_n)
      (el_valid_o && $past(el_valid_o) && op_q == 5'b10000)
      |-> (8'(el_data_o[7:0] - $past(el_data_o[7:0])) <= 8'd1));

   a_r3_index_data: assert property (@(posedge clk) disable iff (!rst_n)
      (el_valid_o && op_q == 5'b10001) |-> (el_data_o[7:0] == 8'(el_idx_o)));

   a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (el_valid_o && sew_q == 2'd0) |-> (el_data_o[ELEN-1:8] == '0));

   a_r6_illegal_idle: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_o |-> (!busy_o && !el_valid_o));

   a_r8_first_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (el_valid_o && el_idx_o == '0) |-> (el_data_o == '0));

   a_r8_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
      (el_valid_o && $past(el_valid_o)) |-> (el_idx_o == $past(el_idx_o) + IDXW'(1)));

   a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   a_r8_done_gap: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !el_valid_o);
endmodule

bind mask_iota_gen mask_iota_gen_chk #(.VLEN(VLEN), .ELEN(ELEN), .IDXW(IDXW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start_i    (start_i),
   .op_i       (op_i),
   .sew_i      (sew_i),
   .busy_o     (busy_o),
   .illegal_o  (illegal_o),
   .done_o     (done_o),
   .el_valid_o (el_valid_o),
   .el_idx_o   (el_idx_o),
   .el_data_o  (el_data_o)
);

// File: tb/mask_iota_gen_tb_top.sv
`timescale 1ns/1ps
module mask_iota_gen_tb_top;
   localparam int VL = 512;
   localparam int EL = 64;
   localparam int IW = $clog2(VL);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic [4:0]    op_i = '0;
   logic [1:0]    sew_i = '0;
   logic [1:0]    lmul_i = '0;
   logic [IW-1:0] vstart_i = '0;
   logic [4:0]    vd_i = '0;
   logic [4:0]    vs2_i = '0;
   logic [VL-1:0] src_mask_i = '0;
   logic [VL-1:0] act_mask_i = '0;
   logic          busy_o, illegal_o, done_o, el_valid_o, el_wr_o;
   logic [IW-1:0] el_idx_o;
   logic [EL-1:0] el_data_o;

   int n_cmp = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   mask_iota_gen #(.VLEN(VL), .ELEN(EL)) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
      .sew_i(sew_i), .lmul_i(lmul_i), .vstart_i(vstart_i), .vd_i(vd_i),
      .vs2_i(vs2_i), .src_mask_i(src_mask_i), .act_mask_i(act_mask_i),
      .busy_o(busy_o), .illegal_o(illegal_o), .done_o(done_o),
      .el_valid_o(el_valid_o), .el_idx_o(el_idx_o), .el_wr_o(el_wr_o),
      .el_data_o(el_data_o)
   );

   task automatic chk(input string req, input string what,
                      input longint act, input longint exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [VL-1:0] mk_mask(input int kind);
      logic [VL-1:0] m;
      for (int w = 0; w < VL / 32; w++) m[w*32 +: 32] = $urandom();
      if (kind == 1) m = '1;
      if (kind == 2) m = '0;
      return m;
   endfunction

   function automatic logic [EL-1:0] trunc_w(input longint v, input logic [1:0] s);
      logic [EL-1:0] keep;
      keep = (s == 2'd3) ? '1 : ((64'd1 << (8 << s)) - 64'd1);
      return EL'(v) & keep;
   endfunction

   task automatic run_ok(input logic [4:0] op, input logic [1:0] s, input logic [1:0] l,
                         input int vst, input logic [4:0] vd, input logic [4:0] vs2,
                         input int skind, input int akind, input bit poke);
      int n;
      int sum;
      int seen;
      logic [VL-1:0] sm, am;
      bit pfx;
      string dtag;
      sm = mk_mask(skind);
      am = mk_mask(akind);
      pfx = (op == 5'b10000);
      dtag = pfx ? "R1" : "R3";
      @(negedge clk);
      op_i = op; sew_i = s; lmul_i = l; vstart_i = IW'(vst);
      vd_i = vd; vs2_i = vs2; src_mask_i = sm; act_mask_i = am; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      n = ((VL / 8) << l) >> s;
      sum = 0;
      seen = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (el_valid_o) seen++;
         chk("R8", "valid", longint'(el_valid_o), 1);
         chk("R8", "index", longint'(el_idx_o), i);
         chk("R2", "write strobe", longint'(el_wr_o), longint'(am[i]));
         chk(dtag, "data", longint'(el_data_o), longint'(trunc_w(pfx ? sum : i, s)));
         if (s == 2'd0)
            chk("R4", "upper bits", longint'(el_data_o >> 8), 0);
         if (pfx && am[i] && sm[i]) sum++;
         if (poke && i == 2) begin
            start_i = 1'b1; op_i = pfx ? 5'b10001 : 5'b10000; sew_i = ~s; lmul_i = ~l;
         end else begin
            start_i = 1'b0;
         end
      end
      @(negedge clk);
      chk("R8", "done", longint'(done_o), 1);
      chk("R8", "valid at done", longint'(el_valid_o), 0);
      chk("R7", "element count", seen, n);
      if (poke) chk("R9", "busy after stray start", longint'(busy_o), 0);
      @(negedge clk);
      chk("R8", "done drop", longint'(done_o), 0);
   endtask

   task automatic run_bad(input logic [4:0] op, input int vst, input logic [4:0] vd,
                          input logic [4:0] vs2, input string tag);
      @(negedge clk);
      op_i = op; sew_i = 2'd1; lmul_i = 2'd0; vstart_i = IW'(vst);
      vd_i = vd; vs2_i = vs2; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk(tag, "illegal pulse", longint'(illegal_o), 1);
      chk(tag, "busy on reject", longint'(busy_o), 0);
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk(tag, "no element", longint'(el_valid_o), 0);
         chk(tag, "no done", longint'(done_o), 0);
         chk(tag, "illegal low", longint'(illegal_o), 0);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      chk("R10", "busy in reset", longint'(busy_o), 0);
      chk("R10", "illegal in reset", longint'(illegal_o), 0);
      chk("R10", "done in reset", longint'(done_o), 0);
      chk("R10", "valid in reset", longint'(el_valid_o), 0);
      chk("R10", "wr in reset", longint'(el_wr_o), 0);
      chk("R10", "data in reset", longint'(el_data_o), 0);
      rst_n = 1'b1;

      run_ok(5'b10000, 2'd0, 2'd3, 0, 5'd2, 5'd3, 1, 1, 1'b0);
      run_ok(5'b10001, 2'd0, 2'd3, 0, 5'd2, 5'd3, 0, 0, 1'b0);
      run_ok(5'b10001, 2'd2, 2'd1, 5, 5'd7, 5'd7, 0, 0, 1'b0);
      run_ok(5'b10000, 2'd3, 2'd0, 0, 5'd1, 5'd4, 1, 0, 1'b1);
      run_ok(5'b10001, 2'd3, 2'd0, 0, 5'd1, 5'd4, 0, 0, 1'b1);
      run_ok(5'b10000, 2'd1, 2'd2, 0, 5'd8, 5'd9, 1, 2, 1'b0);

      run_bad(5'b10000, 3, 5'd2, 5'd3, "R6");
      run_bad(5'b10000, 0, 5'd6, 5'd6, "R6");
      run_bad(5'b10010, 0, 5'd2, 5'd3, "R5");
      run_bad(5'b00000, 0, 5'd2, 5'd3, "R5");

      for (int r = 0; r < 24; r++) begin
         logic [4:0] op, vd;
         logic [1:0] s, l;
         op = ($urandom() % 2 == 0) ? 5'b10000 : 5'b10001;
         s  = 2'($urandom());
         l  = 2'($urandom());
         vd = 5'($urandom());
         run_ok(op, s, l, 0, vd, vd + 5'd1, int'($urandom() % 3), int'($urandom() % 2),
                1'($urandom()));
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule